// File: doc/BRIEF.md
# Shift Pulse Generator with Selectable Prescaler

This block paces the serial arithmetic of a cascadable multiply/divide unit. A start request makes it emit a fixed burst of shift-enable pulses: eight per cascaded device plus one, so 8N+1 for N devices. It then raises a completion strobe. The arithmetic datapath advances one bit on each pulse and never has to count cycles itself.

The pulses come either on every clock or at a slower rate. A prescaler-select input chooses between the two. When the prescaler is on, the slower rate depends on the device count: more cascaded devices mean more carry logic per step, so those systems get a slower step. The prescaler select and the device count are captured when a start is accepted and hold for the whole burst. An active-low clear aborts any burst at once and returns the block to idle.

Top module: `shift_pulse_gen`

## Requirements
- R1: While `clr_n` is low, and in the first cycle after it is released, `shift_en` and `done` are both 0.
- R2: With `presc_sel`=0, pulses arrive on consecutive clock cycles. The first pulse is in the cycle that follows the clock edge at which `start` was accepted.
- R3: With `presc_sel`=1 and `dev_cnt`=00 (one device), there is one pulse every 2 clock cycles. The first pulse comes 2 cycles after the accepting edge.
- R4: With `presc_sel`=1 and `dev_cnt`=01 (two devices), there is one pulse every 4 clock cycles. The first pulse comes 4 cycles after the accepting edge.
- R5: With `presc_sel`=1 and `dev_cnt`=10 or 11 (three or four devices), there is one pulse every 8 clock cycles. The first pulse comes 8 cycles after the accepting edge.
- R6: One burst contains exactly 8N+1 pulses. N is `dev_cnt`+1, so 00 means one device and 11 means four devices.
- R7: When the prescaler is selected, every `shift_en` pulse is high for exactly one clock cycle.
- R8: `done` is high for exactly one cycle: the cycle right after the one that carried the final pulse.
- R9: A `start` that arrives while a burst is running is ignored. So are changes to `presc_sel` or `dev_cnt` during a burst. A `start` in the `done` cycle or later begins a new burst.
- R10: Pulling `clr_n` low during a burst forces `shift_en` to 0 at once and ends the burst without a `done` strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| clr_n | input | 1 | Asynchronous active-low clear |
| start | input | 1 | Start request, sampled at rising clock edges |
| presc_sel | input | 1 | 1 selects the divided pulse rate |
| dev_cnt | input | 2 | Cascaded device count minus one |
| shift_en | output | 1 | Single-bit shift enable for the datapath |
| done | output | 1 | One-cycle completion strobe |

## Verification
Each kind of internal fault shows up at the ports within one burst, and usually within a few cycles.

- A wrong remaining-pulse count makes `done` early or late. It shows at the end of the first burst, no later than 33 pulses in.
- A wrong phase counter or a wrong latched ratio changes the gap before the first pulse. It shows at the very first pulse, at most 8 cycles after start.
- A busy flag that reacts to a start during a burst shifts every later pulse. It shows within one divided period.

The bench compares `shift_en` and `done` against a reference model on every cycle, so each of these faults appears as a mismatch in the cycle where it first occurs.

// File: rtl/spg_pkg.sv
package spg_pkg;
  localparam int DEV_W   = 2;
  localparam int RATIO_W = 3;
  localparam int CNT_W   = 6;

  // Divide ratio minus one for the selected rate.
  function automatic logic [RATIO_W-1:0] ratio_m1(input logic presc,
                                                  input logic [DEV_W-1:0] dev);
    logic [RATIO_W-1:0] r;
    if (!presc)            r = '0;
    else if (dev == 2'd0)  r = RATIO_W'(1);
    else if (dev == 2'd1)  r = RATIO_W'(3);
    else                   r = RATIO_W'(7);
    return r;
  endfunction

  // Pulses in one burst: 8 per device plus one.
  function automatic logic [CNT_W-1:0] pulse_total(input logic [DEV_W-1:0] dev);
    return CNT_W'(8 * (int'(dev) + 1) + 1);
  endfunction
endpackage

// File: rtl/spg_rate_div.sv
module spg_rate_div #(
  parameter int RATIO_W = spg_pkg::RATIO_W
) (
  input  logic               clk,
  input  logic               clr_n,
  input  logic               load,
  input  logic               run,
  input  logic [RATIO_W-1:0] ratio_m1,
  output logic               tick
);
  logic [RATIO_W-1:0] phase;
  logic               wrap;

  assign wrap = (phase == ratio_m1);
  assign tick = run && wrap;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)               phase <= '0;
    else if (load)            phase <= '0;
    else if (run && wrap)     phase <= '0;
    else if (run)             phase <= phase + 1'b1;
  end

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!clr_n)
    (tick && ratio_m1 != '0) |=> !tick);
endmodule

// File: rtl/spg_pulse_ctr.sv
module spg_pulse_ctr #(
  parameter int CNT_W = spg_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load,
  input  logic [CNT_W-1:0] total,
  input  logic             tick,
  output logic             busy,
  output logic             last,
  output logic             done
);
  logic [CNT_W-1:0] remain;

  assign last = busy && tick && (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      remain <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        remain <= total;
        busy   <= 1'b1;
      end else if (busy && tick) begin
        remain <= remain - 1'b1;
        if (last) busy <= 1'b0;
      end
    end
  end

  assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!clr_n)
    last |=> done);
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!clr_n)
    done |=> !done);
endmodule

// File: rtl/shift_pulse_gen.sv
module shift_pulse_gen #(
  parameter int DEV_W   = spg_pkg::DEV_W,
  parameter int RATIO_W = spg_pkg::RATIO_W,
  parameter int CNT_W   = spg_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             start,
  input  logic             presc_sel,
  input  logic [DEV_W-1:0] dev_cnt,
  output logic             shift_en,
  output logic             done
);
  logic               busy;
  logic               accept;
  logic               tick;
  logic               last;
  logic [RATIO_W-1:0] ratio_q;

  assign accept = start && !busy;

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n)      ratio_q <= '0;
    else if (accept) ratio_q <= spg_pkg::ratio_m1(presc_sel, dev_cnt);
  end

  spg_rate_div #(.RATIO_W(RATIO_W)) u_div (
    .clk(clk), .clr_n(clr_n), .load(accept), .run(busy),
    .ratio_m1(ratio_q), .tick(tick)
  );

  spg_pulse_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk(clk), .clr_n(clr_n), .load(accept),
    .total(spg_pkg::pulse_total(dev_cnt)), .tick(tick),
    .busy(busy), .last(last), .done(done)
  );

  assign shift_en = tick;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!clr_n)
    !busy |-> !shift_en);
  assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!clr_n)
    (busy && !last) |=> (busy && $stable(ratio_q)));
  assert_back_to_back_R2: assert property (@(posedge clk) disable iff (!clr_n)
    (tick && ratio_q == '0 && !last) |=> tick);
endmodule

// File: tb/shift_pulse_gen_test.sv
module shift_pulse_gen_test;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       start = 1'b0;
  logic       presc_sel = 1'b0;
  logic [1:0] dev_cnt = 2'd0;
  logic       shift_en, done;

  int checks = 0, errors = 0;
  string req = "R1";

  // reference model state
  bit m_busy = 0, m_done = 0;
  int m_tick = 0, m_left = 0, m_period = 1;

  // per-burst observation
  int n_pulses = 0, last_pulse_cyc = -1, gap_bad = 0, cyc = 0;

  always #2.5 clk = ~clk;

  shift_pulse_gen uut (.clk(clk), .clr_n(clr_n), .start(start), .presc_sel(presc_sel),
                       .dev_cnt(dev_cnt), .shift_en(shift_en), .done(done));

  function automatic int period_of(bit p, int d);
    if (!p) return 1;
    if (d == 0) return 2;
    if (d == 1) return 4;
    return 8;
  endfunction

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d time=%0t", r, act, exp, $time);
    end
  endtask

  // One clock: update model at the edge, compare at the falling edge.
  task automatic step();
    bit nd;
    @(posedge clk);
    nd = 0;
    if (!clr_n) begin
      m_busy = 0; m_left = 0; m_tick = 0;
    end else if (m_busy) begin
      if (m_tick == 1) begin
        m_left--;
        m_tick = m_period;
        if (m_left == 0) begin m_busy = 0; nd = 1; end
      end else m_tick--;
    end else if (start) begin
      m_busy = 1;
      m_period = period_of(presc_sel, dev_cnt);
      m_tick = m_period;
      m_left = 8 * (dev_cnt + 1) + 1;
    end
    m_done = nd;
    @(negedge clk);
    cyc++;
    check({req, " shift_en"}, shift_en, (clr_n && m_busy && m_tick == 1));
    check({req, " done"}, done, (clr_n && m_done));
    if (shift_en) begin
      if (last_pulse_cyc >= 0 && cyc - last_pulse_cyc != m_period) gap_bad++;
      last_pulse_cyc = cyc;
      n_pulses++;
    end
  endtask

  task automatic burst(bit p, int d, string r);
    int waited;
    req = r;
    n_pulses = 0; last_pulse_cyc = -1; gap_bad = 0;
    presc_sel = p; dev_cnt = 2'(d); start = 1'b1;
    step();
    start = 1'b0;
    waited = 0;
    while (!done && waited < 400) begin step(); waited++; end
    check({"R6 pulse count ", r}, n_pulses, 8 * (d + 1) + 1);
    check({r, " gap"}, gap_bad, 0);
    step();
    check("R8 done single", done, 0);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    req = "R1";
    step(); step();
    check("R1 reset shift_en", shift_en, 0);
    check("R1 reset done", done, 0);
    @(negedge clk); clr_n = 1'b1;
    step();
    check("R1 after release", shift_en | done, 0);

    for (int d = 0; d < 4; d++) burst(0, d, "R2");
    burst(1, 0, "R3");
    burst(1, 1, "R4");
    burst(1, 2, "R5");
    burst(1, 3, "R5 R7");

    // R9: start and config changes during a burst are ignored
    req = "R9";
    n_pulses = 0; last_pulse_cyc = -1; gap_bad = 0;
    presc_sel = 1; dev_cnt = 2'd0; start = 1'b1;
    step();
    presc_sel = 0; dev_cnt = 2'd3;
    for (int i = 0; i < 6; i++) step();
    start = 1'b0;
    while (!done) step();
    check("R9 count unchanged", n_pulses, 9);
    check("R9 gap unchanged", gap_bad, 0);
    // start in the done cycle begins a new burst
    start = 1'b1; presc_sel = 0; dev_cnt = 2'd0;
    step();
    start = 1'b0;
    n_pulses = 0; last_pulse_cyc = -1;
    while (!done) step();
    check("R9 restart count", n_pulses, 8);

    // R10: clear mid-burst aborts
    step();
    req = "R10";
    presc_sel = 1; dev_cnt = 2'd2; start = 1'b1;
    step();
    start = 1'b0;
    for (int i = 0; i < 20; i++) step();
    #1 clr_n = 1'b0;
    #0.5;
    check("R10 immediate low", shift_en, 0);
    for (int i = 0; i < 3; i++) step();
    clr_n = 1'b1;
    for (int i = 0; i < 30; i++) step();
    check("R10 no done", done, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule